// File: doc/BRIEF.md
# Paged EEPROM Write Buffer and Address Counter

This block is the memory side of a serial EEPROM model. It sits behind a two-wire protocol engine, which decodes the bus and hands over single-cycle strobes: load the word address, take one write byte, fetch one read byte, and end a transaction (STOP). The block keeps the internal word-address counter and collects incoming write bytes in a page buffer. When a write transaction ends, it commits the buffer to a register-file array and then holds a timed write interval.

Array density and page size are parameters. The default page size is 8 bytes for arrays up to 256 bytes and 16 bytes for larger ones. The write interval is given in system clocks. A write-protect input covers the whole array. In the 2048-byte configuration it covers only the upper half. While the write interval runs, the block reports busy and ignores every strobe. The protocol engine turns a refused read into a missing acknowledge.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset `busy_o` and `rd_valid_o` are 0, the address counter is 0 and the page buffer is empty. Array contents survive reset, and the array starts at 0xFF.
- R2: A read strobe accepted in cycle k raises `rd_valid_o` for one cycle after edge k. `rd_data_o` then holds the array byte at the counter, and the counter advances by one.
- R3: During reads the counter wraps from the last array address to address 0.
- R4: A write strobe stores `wr_data_i` at the counter's in-page offset (the low log2(page) bits). Only that offset is incremented, and it wraps to the start of the same page. A later byte at the same offset replaces an earlier one.
- R5: A commit changes only the byte locations received in the transaction. The rest of the page keeps its old contents.
- R6: A STOP with at least one buffered byte and no protection commits the buffer. `busy_o` is then high for exactly `WR_CYCLES` cycles, starting at the edge that accepts the STOP.
- R7: While `busy_o` is high, address-load, write, read and STOP strobes have no effect, and a read gives no `rd_valid_o`.
- R8: A STOP with an empty buffer commits nothing and does not raise `busy_o`.
- R9: When `wp_i` is high at STOP in a protected region, the buffer is discarded without commit and `busy_o` stays low.
- R10: With 2048 bytes, only addresses 1024 and up are protected. A protected STOP to the lower half commits normally.
- R11: After a commit, the counter holds the last written address plus one, wrapped inside the page, so a current-address read returns that byte.
- R12: An address-load strobe sets the counter to `addr_i` and empties the page buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_load_i | input | 1 | Load word address strobe |
| addr_i | input | log2(MEM_BYTES) | Word address to load |
| wr_byte_i | input | 1 | Write byte strobe |
| wr_data_i | input | 8 | Write byte |
| rd_req_i | input | 1 | Read byte strobe |
| stop_i | input | 1 | Transaction end strobe |
| wp_i | input | 1 | Write protect |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | Read byte valid, one cycle |
| busy_o | output | 1 | Write interval in progress |

## Verification
Strobes are driven on the falling edge and take effect at the next rising edge. Read data and `rd_valid_o` are due one edge after the read strobe, so they are sampled at the falling edge that follows. `busy_o` rises at the edge that accepts the STOP. The bench counts falling-edge samples until it drops, and expects exactly `WR_CYCLES` samples, or none for empty or protected stops. A 128-byte/8-byte-page instance and a 2048-byte/16-byte-page instance receive the same stimulus. Each has its own arithmetic model of counter, pending bytes and array.

// File: rtl/eeprom_page_pkg.sv
package eeprom_page_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_LOAD,
    CMD_WRITE,
    CMD_READ,
    CMD_STOP
  } cmd_e;

  function automatic int unsigned page_bytes_for(int unsigned mem_bytes);
    return (mem_bytes <= 256) ? 8 : 16;
  endfunction
endpackage

// File: rtl/epc_addr_ctr.sv
module epc_addr_ctr #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned OFF_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_page_i,
  input  logic              step_full_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          addr_o <= '0;
    else if (load_i)      addr_o <= load_addr_i;
    else if (step_full_i) addr_o <= addr_o + ADDR_W'(1);
    else if (step_page_i) addr_o <= {addr_o[ADDR_W-1:OFF_W], addr_o[OFF_W-1:0] + OFF_W'(1)};
  end
endmodule

// File: rtl/epc_page_buf.sv
module epc_page_buf #(
  parameter int unsigned PAGE_BYTES = 8,
  parameter int unsigned OFF_W      = 3,
  parameter int unsigned PG_W       = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       wr_i,
  input  logic [OFF_W-1:0]           wr_off_i,
  input  logic [PG_W-1:0]            wr_page_i,
  input  logic [7:0]                 wr_data_i,
  output logic [PAGE_BYTES-1:0][7:0] data_o,
  output logic [PAGE_BYTES-1:0]      valid_o,
  output logic [PG_W-1:0]            page_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= '0;
      page_o  <= '0;
    end else if (clear_i) begin
      valid_o <= '0;
    end else if (wr_i) begin
      valid_o[wr_off_i] <= 1'b1;
      page_o            <= wr_page_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) data_o[wr_off_i] <= wr_data_i;
  end
endmodule

// File: rtl/epc_wr_timer.sv
module epc_wr_timer #(
  parameter int unsigned WR_CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(WR_CYCLES) + 1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CNT_W'(WR_CYCLES - 1);
    end
  end
endmodule

// File: rtl/epc_array.sv
module epc_array #(
  parameter int unsigned MEM_BYTES  = 128,
  parameter int unsigned PAGE_BYTES = 8,
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned OFF_W      = 3,
  parameter int unsigned PG_W       = 4
) (
  input  logic                       clk_i,
  input  logic                       commit_i,
  input  logic [PG_W-1:0]            page_i,
  input  logic [PAGE_BYTES-1:0][7:0] data_i,
  input  logic [PAGE_BYTES-1:0]      valid_i,
  input  logic                       rd_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [7:0]                 rd_data_o
);
  logic [7:0] mem_q [MEM_BYTES];

  // erased state at power-up
  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mem_q[i] = 8'hFF;
  end

  always_ff @(posedge clk_i) begin
    if (commit_i) begin
      for (int j = 0; j < PAGE_BYTES; j++) begin
        if (valid_i[j]) mem_q[{page_i, OFF_W'(j)}] <= data_i[j];
      end
    end
    if (rd_i) rd_data_o <= mem_q[rd_addr_i];
  end
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
  parameter int unsigned MEM_BYTES  = 128,
  parameter int unsigned PAGE_BYTES = eeprom_page_pkg::page_bytes_for(MEM_BYTES),
  parameter int unsigned WR_CYCLES  = 250000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         addr_load_i,
  input  logic [$clog2(MEM_BYTES)-1:0] addr_i,
  input  logic                         wr_byte_i,
  input  logic [7:0]                   wr_data_i,
  input  logic                         rd_req_i,
  input  logic                         stop_i,
  input  logic                         wp_i,
  output logic [7:0]                   rd_data_o,
  output logic                         rd_valid_o,
  output logic                         busy_o
);
  import eeprom_page_pkg::*;

  localparam int unsigned ADDR_W     = $clog2(MEM_BYTES);
  localparam int unsigned OFF_W      = $clog2(PAGE_BYTES);
  localparam int unsigned PG_W       = ADDR_W - OFF_W;
  localparam bit          PROT_UPPER = (MEM_BYTES >= 2048);

  cmd_e                       cmd;
  logic [ADDR_W-1:0]          addr_q;
  logic [PAGE_BYTES-1:0][7:0] buf_data;
  logic [PAGE_BYTES-1:0]      buf_valid;
  logic [PG_W-1:0]            buf_page;
  logic                       in_prot;
  logic                       commit;

  // engine issues at most one strobe per cycle; all are dropped while busy
  always_comb begin
    cmd = CMD_IDLE;
    if (!busy_o) begin
      if      (addr_load_i) cmd = CMD_LOAD;
      else if (wr_byte_i)   cmd = CMD_WRITE;
      else if (rd_req_i)    cmd = CMD_READ;
      else if (stop_i)      cmd = CMD_STOP;
    end
  end

  epc_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cmd == CMD_LOAD),
    .load_addr_i (addr_i),
    .step_page_i (cmd == CMD_WRITE),
    .step_full_i (cmd == CMD_READ),
    .addr_o      (addr_q)
  );

  epc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .PG_W(PG_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   ((cmd == CMD_LOAD) || (cmd == CMD_STOP)),
    .wr_i      (cmd == CMD_WRITE),
    .wr_off_i  (addr_q[OFF_W-1:0]),
    .wr_page_i (addr_q[ADDR_W-1:OFF_W]),
    .wr_data_i (wr_data_i),
    .data_o    (buf_data),
    .valid_o   (buf_valid),
    .page_o    (buf_page)
  );

  generate
    if (PROT_UPPER) begin : g_prot_half
      assign in_prot = buf_page[PG_W-1];
    end else begin : g_prot_full
      assign in_prot = 1'b1;
    end
  endgenerate

  assign commit = (cmd == CMD_STOP) && (|buf_valid) && !(wp_i && in_prot);

  epc_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .busy_o  (busy_o)
  );

  epc_array #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PG_W(PG_W)
  ) u_arr (
    .clk_i     (clk_i),
    .commit_i  (commit),
    .page_i    (buf_page),
    .data_i    (buf_data),
    .valid_i   (buf_valid),
    .rd_i      (cmd == CMD_READ),
    .rd_addr_i (addr_q),
    .rd_data_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_o <= 1'b0;
    else         rd_valid_o <= (cmd == CMD_READ);
  end
endmodule

// File: rtl/eeprom_page_ctrl_chk.sv
module eeprom_page_ctrl_chk #(
  parameter int unsigned WR_CYCLES = 250000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rd_req_i,
  input logic stop_i,
  input logic rd_valid_o,
  input logic busy_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == WR_CYCLES));

  p_busy_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  p_rdv_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ($past(rd_req_i) && !$past(busy_o)));

  p_busy_deaf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_req_i) |=> !rd_valid_o);
endmodule

bind eeprom_page_ctrl eeprom_page_ctrl_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_req_i   (rd_req_i),
  .stop_i     (stop_i),
  .rd_valid_o (rd_valid_o),
  .busy_o     (busy_o)
);

// File: tb/eeprom_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_ctrl_tb_top;
  localparam int W  = 12;
  localparam int SS = 128;
  localparam int SB = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 1'b0, wr = 1'b0, rd = 1'b0, stp = 1'b0, wp = 1'b0;
  logic [10:0] adr = '0;
  logic [7:0]  wd = '0;
  logic [7:0]  rdd_s, rdd_b;
  logic        rdv_s, rdv_b, bsy_s, bsy_b;

  always #10 clk = ~clk;

  eeprom_page_ctrl #(.MEM_BYTES(SS), .WR_CYCLES(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_load_i(ld), .addr_i(adr[6:0]),
    .wr_byte_i(wr), .wr_data_i(wd), .rd_req_i(rd), .stop_i(stp), .wp_i(wp),
    .rd_data_o(rdd_s), .rd_valid_o(rdv_s), .busy_o(bsy_s));

  eeprom_page_ctrl #(.MEM_BYTES(SB), .WR_CYCLES(W)) dut_big_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_load_i(ld), .addr_i(adr),
    .wr_byte_i(wr), .wr_data_i(wd), .rd_req_i(rd), .stop_i(stp), .wp_i(wp),
    .rd_data_o(rdd_b), .rd_valid_o(rdv_b), .busy_o(bsy_b));

  int n_vec = 0, n_err = 0;
  bit done = 0;
  logic [7:0] m_s [SS], pd_s [SS];
  logic [7:0] m_b [SB], pd_b [SB];
  bit pv_s [SS], pv_b [SB];
  int cur_s = 0, cur_b = 0;

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_pend();
    for (int i = 0; i < SS; i++) pv_s[i] = 0;
    for (int i = 0; i < SB; i++) pv_b[i] = 0;
  endtask

  task automatic t_reset(string req);
    rst_n = 1'b0;
    t_step(); t_step();
    rst_n = 1'b1;
    cur_s = 0; cur_b = 0;
    clr_pend();
    chk(req, bsy_s, 0); chk(req, rdv_s, 0);
    chk(req, bsy_b, 0); chk(req, rdv_b, 0);
  endtask

  task automatic t_load(int a);
    bit bs = bsy_s, bb = bsy_b;
    ld = 1'b1; adr = a[10:0];
    t_step();
    ld = 1'b0;
    if (!bs) begin
      cur_s = a % SS;
      for (int i = 0; i < SS; i++) pv_s[i] = 0;
    end
    if (!bb) begin
      cur_b = a % SB;
      for (int i = 0; i < SB; i++) pv_b[i] = 0;
    end
  endtask

  task automatic t_write(logic [7:0] d);
    bit bs = bsy_s, bb = bsy_b;
    wr = 1'b1; wd = d;
    t_step();
    wr = 1'b0;
    if (!bs) begin
      pv_s[cur_s] = 1; pd_s[cur_s] = d;
      cur_s = (cur_s & ~7) | ((cur_s + 1) & 7);
    end
    if (!bb) begin
      pv_b[cur_b] = 1; pd_b[cur_b] = d;
      cur_b = (cur_b & ~15) | ((cur_b + 1) & 15);
    end
  endtask

  task automatic t_read(string req);
    bit bs = bsy_s, bb = bsy_b;
    rd = 1'b1;
    t_step();
    rd = 1'b0;
    chk(req, rdv_s, !bs);
    chk(req, rdv_b, !bb);
    if (!bs) begin
      chk(req, rdd_s, m_s[cur_s]);
      cur_s = (cur_s + 1) % SS;
    end
    if (!bb) begin
      chk(req, rdd_b, m_b[cur_b]);
      cur_b = (cur_b + 1) % SB;
    end
  endtask

  task automatic t_idle();
    while (bsy_s || bsy_b) t_step();
  endtask

  task automatic t_stop(bit wait_done, string req);
    bit bs = bsy_s, bb = bsy_b;
    bit any_s = 0, any_b = 0, up_b = 0, es = 0, eb = 0;
    int ns, nb;
    for (int i = 0; i < SS; i++) if (pv_s[i]) any_s = 1;
    for (int i = 0; i < SB; i++) if (pv_b[i]) begin any_b = 1; if (i >= 1024) up_b = 1; end
    if (!bs) begin
      es = any_s && !wp;
      if (es) for (int i = 0; i < SS; i++) if (pv_s[i]) m_s[i] = pd_s[i];
      for (int i = 0; i < SS; i++) pv_s[i] = 0;
    end
    if (!bb) begin
      eb = any_b && !(wp && up_b);
      if (eb) for (int i = 0; i < SB; i++) if (pv_b[i]) m_b[i] = pd_b[i];
      for (int i = 0; i < SB; i++) pv_b[i] = 0;
    end
    stp = 1'b1;
    t_step();
    stp = 1'b0;
    if (!bs) chk(req, bsy_s, es);
    if (!bb) chk(req, bsy_b, eb);
    if (wait_done) begin
      ns = bsy_s ? 1 : 0;
      nb = bsy_b ? 1 : 0;
      while (bsy_s || bsy_b) begin
        t_step();
        if (bsy_s) ns++;
        if (bsy_b) nb++;
      end
      chk({req, " R6 length"}, ns, es ? W : 0);
      chk({req, " R6 length"}, nb, eb ? W : 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SS; i++) begin m_s[i] = 8'hFF; pv_s[i] = 0; end
    for (int i = 0; i < SB; i++) begin m_b[i] = 8'hFF; pv_b[i] = 0; end
    @(negedge clk);
    t_reset("R1");
    t_read("R1");
    t_load(5);
    t_stop(1, "R8");

    // R4 R6 R11: every page, start offset moves, full page wraps inside page
    for (int p = 0; p < 16; p++) begin
      t_load(p * 8 + (p % 8));
      for (int i = 0; i < 8; i++) t_write(8'((p * 37 + i * 11 + 1) & 255));
      t_stop(1, "R6");
      t_read("R11");
    end

    // R2 R3: full sweep, wrap on the small array
    t_load(0);
    for (int i = 0; i < 129; i++) t_read(i == 128 ? "R3" : "R2");
    t_load(2047);
    t_read("R3");
    t_read("R3");

    // R4: ten bytes into an eight-byte page
    t_load(30);
    for (int i = 0; i < 10; i++) t_write(8'(8'hA0 + i));
    t_stop(1, "R4");
    t_load(24);
    for (int i = 0; i < 8; i++) t_read("R4");

    // R5: partial page
    t_load(42);
    for (int i = 0; i < 3; i++) t_write(8'(8'h30 + i));
    t_stop(1, "R5");
    t_load(40);
    for (int i = 0; i < 16; i++) t_read("R5");

    // R7: strobes during busy
    t_load(64);
    t_write(8'h5C);
    t_write(8'h5D);
    t_stop(0, "R6");
    t_read("R7");
    t_load(100);
    t_write(8'h11);
    t_stop(0, "R7");
    t_idle();
    t_read("R7");
    t_load(64);
    for (int i = 0; i < 3; i++) t_read("R7");

    // R9 R10: write protect
    wp = 1'b1;
    t_load(16);
    for (int i = 0; i < 4; i++) t_write(8'(8'hC0 + i));
    t_stop(1, "R9");
    t_load(1040);
    for (int i = 0; i < 4; i++) t_write(8'(8'hD0 + i));
    t_stop(1, "R10");
    wp = 1'b0;
    t_load(16);
    for (int i = 0; i < 4; i++) t_read("R9");
    t_load(1040);
    for (int i = 0; i < 4; i++) t_read("R10");

    // R12: load discards buffered bytes
    t_load(72);
    t_write(8'h77);
    t_load(80);
    t_stop(1, "R12");
    t_load(72);
    t_read("R12");

    // R1: reset clears counter and buffer, keeps array
    t_load(70);
    t_write(8'h42);
    t_reset("R1");
    t_stop(1, "R1");
    t_read("R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule